// File: doc/BRIEF.md
# Configuration Bus Transaction Controller

This block lets software run one configuration access at a time against a function that sits on a remote board. Software works through three memory-mapped words: a data word, a control word and a status word. A typical access has four steps. Software clears the status word by writing zero and loads the data word (for a write). It then writes the control word with its start bit set. Finally it polls the status word until it becomes nonzero.

When the start bit is written, the controller presents a single request on a valid/ready port. The request carries the direction, the target fields and the data word. The controller then waits for the matching response. A good response sets the completion bit, and for a read the returned value is loaded into the data word. An error response sets the error bit and leaves the data word as it was. If no response arrives within a programmable number of cycles, the access also ends with the error bit set. The start bit reads back as 1 for the whole time the access is in flight. It drops in the same cycle that a status bit rises.

Top module: `cfg_xact_ctrl`

## Requirements
- R1: The data word is at byte offset 0x0A0, the control word at 0x0A4 and the status word at 0x0A8. Any other offset reads as zero, and writes to it change nothing.
- R2: Control word bit fields are: start in bit 31, write in bit 30, controller in 29:26, function in 25:20, site in 17:16, position in 15:12 and device in 11:0. Bits 19:18 read as zero. The request presents these fields on its own pins, together with the data word.
- R3: A control write with bit 31 set while idle launches exactly one request, and bit 31 reads as 1 until the access ends. A control write with bit 31 clear only stores the fields and launches nothing.
- R4: The request stays valid, with an unchanged payload, until it is accepted with ready.
- R5: A good response (error flag low) sets status bit 0 and clears the start bit in the same cycle. After a read, the data word holds the response data. After a write, the data word keeps the value that was sent.
- R6: A response with the error flag high sets status bit 1 and leaves the data word unchanged.
- R7: If no response is taken within `tmo_limit` cycles of launch, the access ends with status bit 1 set. A limit of zero disables this timeout.
- R8: While an access is in flight, writes to the control word and to the data word are ignored.
- R9: Writing zero to the status word clears both status bits. Writing a nonzero value to it has no effect.
- R10: After reset the data, control and status words read as zero and no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write access, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tmo_limit | input | TMO_W | Response timeout in cycles, 0 disables |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted |
| req_write | output | 1 | Request direction, 1 = write |
| req_ctlr | output | 4 | Controller number |
| req_func | output | 6 | Function number |
| req_site | output | 2 | Site |
| req_pos | output | 4 | Position |
| req_dev | output | 12 | Device number |
| req_data | output | 32 | Data word sent with the request |
| rsp_valid | input | 1 | Response present |
| rsp_data | input | 32 | Returned read data |
| rsp_err | input | 1 | Response reports failure |

## Verification
The bench runs several kinds of access through the same sequence and compares them:
- A write with an immediate answer, and a read with both ready and response delayed. These show that the read loads the data word and the write does not.
- An error reply on a read, which must leave the canary value in the data word.
- A silent target with a short limit, and a slow target with the limit switched off. These separate the timeout path from a normal late answer.
- An access that is hit with control and data writes while it is in flight. This shows the busy guard: the payload the responder sees and the readback words stay those of the first command, and only one handshake occurs.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam logic [11:0] OFS_DATA = 12'h0A0;
  localparam logic [11:0] OFS_CTRL = 12'h0A4;
  localparam logic [11:0] OFS_STAT = 12'h0A8;

  // Field positions matter: remote functions decode them.
  typedef struct packed {
    logic        start;
    logic        wr;
    logic [3:0]  ctlr;
    logic [5:0]  func;
    logic [1:0]  unused_gap;
    logic [1:0]  site;
    logic [3:0]  pos;
    logic [11:0] dev;
  } ctrl_word_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_t;

  // Stored copy of a written command: start and gap bits dropped.
  function automatic ctrl_word_t ctrl_store(logic [31:0] w);
    ctrl_word_t c;
    c = ctrl_word_t'(w);
    c.start = 1'b0;
    c.unused_gap = 2'b00;
    return c;
  endfunction

  // Readback of the control word with the live busy flag in bit 31.
  function automatic logic [31:0] ctrl_view(ctrl_word_t c, logic busy);
    ctrl_word_t v;
    v = c;
    v.start = busy;
    v.unused_gap = 2'b00;
    return 32'(v);
  endfunction

  // Status update: a zero write clears, then completion events set bits.
  function automatic logic [1:0] stat_next(logic [1:0] cur, logic clr,
                                           logic ok, logic err);
    logic [1:0] n;
    n = clr ? 2'b00 : cur;
    n[0] = n[0] | ok;
    n[1] = n[1] | err;
    return n;
  endfunction

endpackage

// File: rtl/cfgx_timer.sv
module cfgx_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             active,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);

  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic [TMO_W-1:0] cnt_q;

  function automatic logic limit_reached(logic [TMO_W-1:0] cnt,
                                         logic [TMO_W-1:0] lim);
    return (lim != '0) && (cnt == lim - ONE);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (launch) cnt_q <= '0;
    else if (active) cnt_q <= cnt_q + ONE;
  end

  assign expire = active & limit_reached(cnt_q, limit);

  // R7
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && limit != '0 && $stable(limit)) |-> (cnt_q < limit));

endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
  import cfgx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic expire,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic rsp_err,
  output logic req_valid,
  output logic done_ok,
  output logic done_err
);

  seq_state_t state_q, state_d;
  logic       take;

  assign take      = (state_q == SQ_WAIT) & rsp_valid;
  assign done_ok   = take & ~rsp_err;
  assign done_err  = (take & rsp_err) | (expire & ~take);
  assign req_valid = (state_q == SQ_REQ);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (launch) state_d = SQ_REQ;
      SQ_REQ: begin
        if (expire)         state_d = SQ_IDLE;
        else if (req_ready) state_d = SQ_WAIT;
      end
      SQ_WAIT: if (done_ok || done_err) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  // R3
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (state_q == SQ_IDLE));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !expire) |=> req_valid);

  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_err));

endmodule

// File: rtl/cfgx_regs.sv
module cfgx_regs
  import cfgx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        done_ok,
  input  logic        done_err,
  input  logic [31:0] rsp_data,
  output logic        launch,
  output logic        busy,
  output ctrl_word_t  cmd,
  output logic [31:0] data_word
);

  ctrl_word_t  cmd_q;
  logic        start_q;
  logic [31:0] data_q;
  logic [1:0]  stat_q;

  logic wr_data_evt, wr_ctrl_evt, wr_stat_evt, clr_evt, load_evt;

  assign wr_data_evt = bus_sel & bus_wr & (bus_addr == OFS_DATA) & ~start_q;
  assign wr_ctrl_evt = bus_sel & bus_wr & (bus_addr == OFS_CTRL) & ~start_q;
  assign wr_stat_evt = bus_sel & bus_wr & (bus_addr == OFS_STAT);
  assign clr_evt     = wr_stat_evt & (bus_wdata == 32'h0);
  assign launch      = wr_ctrl_evt & bus_wdata[31];
  assign load_evt    = done_ok & ~cmd_q.wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      start_q <= 1'b0;
      data_q  <= '0;
      stat_q  <= '0;
    end else begin
      if (wr_ctrl_evt) cmd_q <= ctrl_store(bus_wdata);
      if (launch)                   start_q <= 1'b1;
      else if (done_ok || done_err) start_q <= 1'b0;
      if (wr_data_evt)   data_q <= bus_wdata;
      else if (load_evt) data_q <= rsp_data;
      stat_q <= stat_next(stat_q, clr_evt, done_ok, done_err);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        OFS_DATA: bus_rdata = data_q;
        OFS_CTRL: bus_rdata = ctrl_view(cmd_q, start_q);
        OFS_STAT: bus_rdata = {30'h0, stat_q};
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign busy      = start_q;
  assign cmd       = cmd_q;
  assign data_word = data_q;

  // R8
  busy_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && bus_sel && bus_wr && bus_addr == OFS_CTRL) |=> $stable(cmd_q));

  // R8
  busy_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !done_ok) |=> $stable(data_q));

  // R6
  err_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |=> $stable(data_q));

  // R5
  done_clears_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_err) |=> (!start_q && stat_q != 2'b00));

  // R9
  nonzero_stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat_evt && !clr_evt && !done_ok && !done_err) |=> $stable(stat_q));

endmodule

// File: rtl/cfg_xact_ctrl.sv
module cfg_xact_ctrl
  import cfgx_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [3:0]       req_ctlr,
  output logic [5:0]       req_func,
  output logic [1:0]       req_site,
  output logic [3:0]       req_pos,
  output logic [11:0]      req_dev,
  output logic [31:0]      req_data,
  input  logic             rsp_valid,
  input  logic [31:0]      rsp_data,
  input  logic             rsp_err
);

  logic       launch_evt, busy_w, expire_evt, done_ok_evt, done_err_evt;
  ctrl_word_t cmd_w;
  logic [31:0] data_w;

  cfgx_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .done_ok   (done_ok_evt),
    .done_err  (done_err_evt),
    .rsp_data  (rsp_data),
    .launch    (launch_evt),
    .busy      (busy_w),
    .cmd       (cmd_w),
    .data_word (data_w)
  );

  cfgx_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch_evt),
    .expire    (expire_evt),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .req_valid (req_valid),
    .done_ok   (done_ok_evt),
    .done_err  (done_err_evt)
  );

  cfgx_timer #(.TMO_W(TMO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch_evt),
    .active (busy_w),
    .limit  (tmo_limit),
    .expire (expire_evt)
  );

  assign req_write = cmd_w.wr;
  assign req_ctlr  = cmd_w.ctlr;
  assign req_func  = cmd_w.func;
  assign req_site  = cmd_w.site;
  assign req_pos   = cmd_w.pos;
  assign req_dev   = cmd_w.dev;
  assign req_data  = data_w;

  // R4
  req_payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !expire_evt) |=>
      ($stable(req_data) && $stable(req_dev) && $stable(req_func) &&
       $stable(req_write) && $stable(req_site) && $stable(req_pos) &&
       $stable(req_ctlr)));

  // R3
  valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy_w);

endmodule

// File: tb/cfg_xact_ctrl_test.sv
module cfg_xact_ctrl_test;

  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [TW-1:0] tmo_limit = '0;
  logic          req_valid, req_ready, req_write;
  logic [3:0]    req_ctlr, req_pos;
  logic [5:0]    req_func;
  logic [1:0]    req_site;
  logic [11:0]   req_dev;
  logic [31:0]   req_data, rsp_data;
  logic          rsp_valid, rsp_err;

  always #2 clk = ~clk;

  cfg_xact_ctrl #(.TMO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmo_limit(tmo_limit), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_ctlr(req_ctlr), .req_func(req_func),
    .req_site(req_site), .req_pos(req_pos), .req_dev(req_dev),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err)
  );

  localparam logic [11:0] A_DATA = 12'h0A0, A_CTRL = 12'h0A4, A_STAT = 12'h0A8;

  typedef struct {
    bit          wr;
    logic [3:0]  c;
    logic [5:0]  f;
    logic [1:0]  s;
    logic [3:0]  p;
    logic [11:0] d;
    logic [31:0] data;
    int          rdy_dly;
    int          rsp_dly;
    bit          no_rsp;
    bit          err;
    logic [31:0] rdat;
  } item_t;

  item_t exp_q[$];
  int compared = 0, mismatched = 0, handshakes = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(bit st, item_t it);
    return (32'(st) << 31) | (32'(it.wr) << 30) | (32'(it.c) << 26) |
           (32'(it.f) << 20) | (32'(it.s) << 16) | (32'(it.p) << 12) |
           32'(it.d);
  endfunction

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  // Responder: models the remote side and checks each request payload.
  initial begin
    item_t it;
    req_ready = 0; rsp_valid = 0; rsp_data = '0; rsp_err = 0;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        if (exp_q.size() == 0) begin
          chk("R3 request with none queued", 32'(req_valid), 32'h0);
          req_ready = 1; @(negedge clk); req_ready = 0;
        end else begin
          it = exp_q.pop_front();
          repeat (it.rdy_dly) @(negedge clk);
          chk("R4 valid held", 32'(req_valid), 32'h1);
          chk("R2 write flag", 32'(req_write), 32'(it.wr));
          chk("R2 fields", {req_ctlr, req_func, req_site, req_pos, req_dev},
              {it.c, it.f, it.s, it.p, it.d});
          chk("R2 data", req_data, it.data);
          req_ready = 1; @(negedge clk); req_ready = 0;
          handshakes++;
          if (!it.no_rsp) begin
            repeat (it.rsp_dly) @(negedge clk);
            rsp_valid = 1; rsp_data = it.rdat; rsp_err = it.err;
            @(negedge clk);
            rsp_valid = 0; rsp_err = 0;
          end
        end
      end
    end
  end

  task automatic run_xact(item_t it, logic [31:0] exp_stat, logic [31:0] exp_data,
                          string tag);
    logic [31:0] v;
    int n;
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, v);
    chk({tag, " R9 clear before launch"}, v, 32'h0);
    bus_write(A_DATA, it.data);
    exp_q.push_back(it);
    bus_write(A_CTRL, mk_ctrl(1, it));
    bus_read(A_CTRL, v);
    chk({tag, " R3 start reads busy"}, v, mk_ctrl(1, it));
    n = 0;
    do begin
      bus_read(A_STAT, v);
      n++;
    end while (v == 0 && n < 5000);
    chk({tag, " status"}, v, exp_stat);
    bus_read(A_CTRL, v);
    chk({tag, " R5 start cleared"}, v, mk_ctrl(0, it));
    bus_read(A_DATA, v);
    chk({tag, " data word"}, v, exp_data);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    item_t it, it2;
    int hs;
    tmo_limit = 16'd200;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R10 reset state
    bus_read(A_DATA, v); chk("R10 data after reset", v, 0);
    bus_read(A_CTRL, v); chk("R10 ctrl after reset", v, 0);
    bus_read(A_STAT, v); chk("R10 status after reset", v, 0);
    chk("R10 no request", 32'(req_valid), 0);

    // R1 unmapped offsets
    bus_write(12'h0AC, 32'hFFFF_FFFF);
    bus_read(12'h0AC, v); chk("R1 unmapped reads zero", v, 0);
    bus_read(12'h000, v); chk("R1 offset 0 reads zero", v, 0);
    bus_read(A_DATA, v); chk("R1 stray write left data", v, 0);

    // R5 write access, immediate answer
    it = '{wr:1, c:4'h3, f:6'h15, s:2'h2, p:4'h9, d:12'hABC, data:32'hCAFE_F00D,
           rdy_dly:0, rsp_dly:0, no_rsp:0, err:0, rdat:32'h0000_1234};
    run_xact(it, 32'h1, 32'hCAFE_F00D, "R5 write");

    // R5 read access with backpressure (R4) and slow answer
    it = '{wr:0, c:4'hF, f:6'h2A, s:2'h1, p:4'h0, d:12'h005, data:32'h5A5A_0F0F,
           rdy_dly:4, rsp_dly:3, no_rsp:0, err:0, rdat:32'h8765_4321};
    run_xact(it, 32'h1, 32'h8765_4321, "R5 read");

    // R6 error answer keeps canary
    it.rdat = 32'hFFFF_0000; it.err = 1; it.rdy_dly = 0;
    run_xact(it, 32'h2, 32'h5A5A_0F0F, "R6 error");

    // R7 silent target, short limit
    tmo_limit = 16'd20;
    it.err = 0; it.no_rsp = 1;
    run_xact(it, 32'h2, 32'h5A5A_0F0F, "R7 timeout");

    // R7 limit zero disables the timeout
    tmo_limit = 16'd0;
    it.no_rsp = 0; it.rsp_dly = 60; it.rdat = 32'h0F0F_1111;
    run_xact(it, 32'h1, 32'h0F0F_1111, "R7 disabled");
    tmo_limit = 16'd200;

    // R8 writes while busy are ignored
    it = '{wr:1, c:4'h1, f:6'h01, s:2'h0, p:4'h2, d:12'h310, data:32'h0BAD_F00D,
           rdy_dly:0, rsp_dly:40, no_rsp:0, err:0, rdat:32'h0};
    it2 = it; it2.c = 4'h7; it2.d = 12'hFFF;
    hs = handshakes;
    bus_write(A_STAT, 0);
    bus_write(A_DATA, it.data);
    exp_q.push_back(it);
    bus_write(A_CTRL, mk_ctrl(1, it));
    bus_write(A_CTRL, mk_ctrl(1, it2));
    bus_write(A_DATA, 32'h1111_2222);
    bus_read(A_CTRL, v); chk("R8 control kept while busy", v, mk_ctrl(1, it));
    bus_read(A_DATA, v); chk("R8 data kept while busy", v, 32'h0BAD_F00D);
    do bus_read(A_STAT, v); while (v == 0);
    chk("R8 busy access completes", v, 1);
    repeat (20) @(negedge clk);
    chk("R8 single handshake", 32'(handshakes - hs), 1);

    // R9 nonzero status write ignored, zero clears
    bus_write(A_STAT, 32'h4);
    bus_read(A_STAT, v); chk("R9 nonzero write ignored", v, 1);
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, v); chk("R9 zero write clears", v, 0);

    // R3 start clear only stores; R2 gap bits read zero
    hs = handshakes;
    it = '{wr:0, c:4'hA, f:6'h3F, s:2'h3, p:4'hC, d:12'h777, data:32'h0,
           rdy_dly:0, rsp_dly:0, no_rsp:0, err:0, rdat:32'h0};
    bus_write(A_CTRL, mk_ctrl(0, it) | 32'h000C_0000);
    repeat (5) @(negedge clk);
    bus_read(A_CTRL, v); chk("R2 R3 stored fields, gap zero", v, mk_ctrl(0, it));
    chk("R3 no launch without start", 32'(handshakes - hs), 0);
    chk("R3 no request valid", 32'(req_valid), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule